// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the protocol engine of a 2 KB memory that answers on an I2C bus. It receives SCL and SDA levels that have already been filtered, together with one-cycle start and stop strobes from an upstream condition detector. It drives a single open-drain enable for SDA, where a high enable pulls the line low. All logic runs on a system clock that is much faster than SCL. The engine finds SCL edges by comparing each SCL sample with the one taken a cycle earlier.

A transaction opens with an address byte. That byte carries a fixed device code, three block bits and a direction bit. A write transaction then takes one more byte, the low half of the word address, and after it a stream of data bytes. Each data byte is passed to a write-commit controller as an address/data pair. When the stop arrives, a one-cycle commit request is raised. A read transaction streams bytes out of the memory port, starting at the word pointer, for as long as the master acknowledges them. The pointer is kept between transactions, so a current-address read, a random read (a dummy write and then a repeated start) and a sequential read all use the same register. While the commit controller reports busy, the engine does not acknowledge its address. A master polls on that to learn when the write cycle has finished.

The states are named as follows. IDLE waits for a start. ADDR shifts in the address byte. AACK acknowledges the address. WADR shifts in the word address. WACK acknowledges it. WDAT shifts in a data byte. DACK acknowledges the data byte. RDAT shifts a byte out. RACK samples the master's acknowledge. WSTOP holds the engine silent until the next start or stop.

The transitions are:
- A start strobe moves any state to ADDR.
- A stop strobe moves any state to IDLE.
- ADDR goes to AACK when the device code matches and the commit controller is not busy. Otherwise ADDR goes to WSTOP.
- AACK goes to RDAT on a read and to WADR on a write.
- WADR goes to WACK.
- WACK and DACK go to WDAT.
- WDAT goes to DACK.
- RDAT goes to RACK.
- RACK goes to RDAT on an acknowledge and to WSTOP on a no-acknowledge.

Top module: `i2c_mem_slave`

## Requirements
- R1: An address byte is matched when its bits 7..4 equal 1010. Bits 3..1 carry the block number and bit 0 selects read (1) or write (0). A matched address is acknowledged by pulling SDA low for the whole ninth SCL clock.
- R2: When bits 7..4 of an address byte are not 1010, the engine gives no acknowledge. It does not drive SDA, writes nothing and leaves the pointer unchanged until the next start or stop.
- R3: In a write transaction, the second byte becomes pointer bits 7..0, and the block number of the address byte becomes pointer bits 10..8. Every later byte is acknowledged and presented once on wr_en/wr_addr/wr_data at the current pointer. The pointer then advances by one.
- R4: Bits travel MSB first. Incoming bits are sampled on the rising edge of SCL, and the SDA enable changes only while SCL is low, except when a start or stop strobe forces it to release.
- R5: After a read address has been acknowledged, the engine sends the byte found at the pointer, MSB first. The pointer advances by one for each byte loaded for sending.
- R6: During a read, an acknowledge from the master on the ninth clock makes the engine send the next byte. A no-acknowledge makes it release SDA and stay silent until a start or stop.
- R7: After a read or write of address n, the pointer (seen on mem_addr) holds n+1, and the next current-address read returns the byte at n+1.
- R8: A write that stops after the word address and is then followed by a repeated start with a read address returns the byte at the loaded address. It presents no write.
- R9: The pointer wraps from 2047 to 0, so a sequential read continues at address 0 after the last byte.
- R10: While commit_busy is high at the eighth address bit, the address byte is not acknowledged.
- R11: A repeated start in the middle of a byte discards the partial byte, presents no write and returns the engine to address reception.
- R12: A stop that ends a transaction in which at least one data byte was written raises commit_req for exactly one cycle. A stop after a transaction with no data bytes raises nothing.
- R13: After reset the SDA enable is low, the pointer is 0 and neither wr_en nor commit_req is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Filtered SCL level |
| sda_in | input | 1 | Filtered SDA level as seen on the bus |
| start_det | input | 1 | One-cycle strobe for a start or repeated start |
| stop_det | input | 1 | One-cycle strobe for a stop |
| commit_busy | input | 1 | Write-commit controller is still running a write cycle |
| mem_rdata | input | 8 | Read data of the memory array at mem_addr |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| mem_addr | output | 11 | Word pointer, used as the array read address |
| wr_en | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 11 | Address of the received data byte |
| wr_data | output | 8 | Received data byte |
| commit_req | output | 1 | One-cycle request to start the write cycle |

## Verification
The embedded properties check four things on every cycle. The SDA enable never changes during an SCL high phase unless a start or stop strobe forces it. No acknowledge state is entered while the commit controller is busy. Write strobes come only out of data reception, and commit requests only out of a stop. The pointer rolls from its top value to zero.

Some behaviour only the scenarios can show, because it depends on whole transactions. These are the byte order and content on the bus, the pointer being kept across transactions, a random read built from a dummy write, a sequential read wrapping past address 2047, and silence after a foreign device code, a no-acknowledge or a repeated start in mid-byte. A behavioural memory and pointer model in the bench gives the expected value for each of them.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WADR,
        ST_WACK,
        ST_WDAT,
        ST_DACK,
        ST_RDAT,
        ST_RACK,
        ST_WSTOP
    } eng_state_t;

endpackage

// File: rtl/i2cmem_scl_edges.sv
module i2cmem_scl_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d;

    // Reset to 1: the bus idles high, so no false edge appears out of reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_d <= 1'b1;
        else        scl_d <= scl_lvl;
    end

    assign scl_rise = scl_lvl & ~scl_d;
    assign scl_fall = ~scl_lvl & scl_d;

endmodule

// File: rtl/i2cmem_word_ptr.sv
module i2cmem_word_ptr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr_q <= '0;
        else if (load) ptr_q <= load_val;
        else if (inc)  ptr_q <= ptr_q + AW'(1);
    end

    assign ptr = ptr_q;

    // R9
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc) && !$past(load) && ($past(ptr_q) == {AW{1'b1}})) |-> (ptr_q == '0));

endmodule

// File: rtl/i2cmem_fsm.sv
module i2cmem_fsm
    import i2cmem_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic              start_stb,
    input  logic              stop_stb,
    input  logic              busy,
    input  logic [AW-1:0]     ptr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              ptr_load,
    output logic [AW-1:0]     ptr_load_val,
    output logic              ptr_inc,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              commit_req
);
    localparam int BLK_W = AW - BYTE_W;

    eng_state_t        st_q, st_n;
    logic [3:0]        cnt_q, cnt_n;
    logic [BYTE_W-1:0] sh_q, sh_n;
    logic [BLK_W-1:0]  blk_q, blk_n;
    logic              rw_q, rw_n;
    logic              mack_q, mack_n;
    logic              hw_q, hw_n;
    logic              wr_en_n, commit_n;
    logic [BYTE_W-1:0] byte_in;

    assign byte_in = {sh_q[BYTE_W-2:0], sda_in};

    // Next-state and datapath
    always_comb begin
        st_n         = st_q;
        cnt_n        = cnt_q;
        sh_n         = sh_q;
        blk_n        = blk_q;
        rw_n         = rw_q;
        mack_n       = mack_q;
        hw_n         = hw_q;
        ptr_load     = 1'b0;
        ptr_load_val = '0;
        ptr_inc      = 1'b0;
        wr_en_n      = 1'b0;
        commit_n     = 1'b0;
        if (start_stb) begin
            st_n  = ST_ADDR;
            cnt_n = 4'd0;
        end else if (stop_stb) begin
            st_n     = ST_IDLE;
            cnt_n    = 4'd0;
            commit_n = hw_q;
            hw_n     = 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_WSTOP: begin
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh_n = byte_in;
                        if (cnt_q == 4'd7) begin
                            cnt_n = 4'd0;
                            if (byte_in[7:4] == DEV_CODE && !busy) begin
                                st_n  = ST_AACK;
                                rw_n  = byte_in[0];
                                blk_n = byte_in[BLK_W:1];
                            end else begin
                                st_n = ST_WSTOP;
                            end
                        end else begin
                            cnt_n = cnt_q + 4'd1;
                        end
                    end
                end
                ST_WADR, ST_WDAT: begin
                    if (scl_rise) begin
                        sh_n = byte_in;
                        if (cnt_q == 4'd7) begin
                            cnt_n = 4'd0;
                            if (st_q == ST_WADR) begin
                                st_n         = ST_WACK;
                                ptr_load     = 1'b1;
                                ptr_load_val = {blk_q, byte_in};
                            end else begin
                                st_n    = ST_DACK;
                                wr_en_n = 1'b1;
                                ptr_inc = 1'b1;
                                hw_n    = 1'b1;
                            end
                        end else begin
                            cnt_n = cnt_q + 4'd1;
                        end
                    end
                end
                ST_AACK, ST_WACK, ST_DACK: begin
                    // cnt: 0 = before drive, 1 = driving low, 2 = ninth clock sampled
                    if (scl_fall && cnt_q == 4'd0) begin
                        cnt_n = 4'd1;
                    end else if (scl_rise && cnt_q == 4'd1) begin
                        cnt_n = 4'd2;
                    end else if (scl_fall && cnt_q == 4'd2) begin
                        cnt_n = 4'd0;
                        if (st_q == ST_AACK && rw_q) begin
                            st_n    = ST_RDAT;
                            sh_n    = mem_rdata;
                            ptr_inc = 1'b1;
                        end else if (st_q == ST_AACK) begin
                            st_n = ST_WADR;
                        end else begin
                            st_n = ST_WDAT;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        cnt_n = cnt_q + 4'd1;
                    end else if (scl_fall) begin
                        if (cnt_q == 4'd8) begin
                            st_n  = ST_RACK;
                            cnt_n = 4'd0;
                        end else begin
                            sh_n = {sh_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_n = ~sda_in;
                        cnt_n  = 4'd1;
                    end else if (scl_fall && cnt_q == 4'd1) begin
                        cnt_n = 4'd0;
                        if (mack_q) begin
                            st_n    = ST_RDAT;
                            sh_n    = mem_rdata;
                            ptr_inc = 1'b1;
                        end else begin
                            st_n = ST_WSTOP;
                        end
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cnt_q      <= 4'd0;
            sh_q       <= '0;
            blk_q      <= '0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            hw_q       <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            commit_req <= 1'b0;
        end else begin
            st_q       <= st_n;
            cnt_q      <= cnt_n;
            sh_q       <= sh_n;
            blk_q      <= blk_n;
            rw_q       <= rw_n;
            mack_q     <= mack_n;
            hw_q       <= hw_n;
            wr_en      <= wr_en_n;
            commit_req <= commit_n;
            if (wr_en_n) begin
                wr_addr <= ptr;
                wr_data <= byte_in;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            ST_AACK, ST_WACK, ST_DACK: sda_oe = (cnt_q != 4'd0);
            ST_RDAT:                   sda_oe = ~sh_q[BYTE_W-1];
            default:                   sda_oe = 1'b0;
        endcase
    end

    // R4
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(start_stb) && !$past(stop_stb)) |-> !$past(scl_lvl));

    // R10
    busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_AACK) && ($past(st_q) != ST_AACK)) |-> !$past(busy));

    // R3
    wr_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(st_q) == ST_WDAT));

    // R12
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> $past(stop_stb));

    // R12
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |=> !commit_req);

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2cmem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              commit_busy,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              commit_req
);
    logic              scl_rise, scl_fall;
    logic              ptr_load, ptr_inc;
    logic [ADDR_W-1:0] ptr_load_val, ptr;

    i2cmem_scl_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_in),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2cmem_word_ptr #(.AW(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    i2cmem_fsm #(.AW(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_lvl      (scl_in),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .sda_in       (sda_in),
        .start_stb    (start_det),
        .stop_stb     (stop_det),
        .busy         (commit_busy),
        .ptr          (ptr),
        .mem_rdata    (mem_rdata),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_inc      (ptr_inc),
        .sda_oe       (sda_oe),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .commit_req   (commit_req)
    );

    assign mem_addr = ptr;

endmodule

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_N = 2048;

    logic        clk = 1'b0;
    logic        rst_n, scl, m_sda, start_stb, stop_stb, busy, quiet;
    logic        sda_line, sda_oe, wr_en, commit_req;
    logic [7:0]  mem_rdata, wr_data;
    logic [10:0] mem_addr, wr_addr;

    logic [7:0]  mem     [0:MEM_N-1];
    logic [7:0]  ref_mem [0:MEM_N-1];
    int          ref_ptr = 0;
    int          checks = 0, errors = 0, commit_cnt = 0, wr_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (commit_req) commit_cnt <= commit_cnt + 1;
    end

    i2c_mem_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .start_det(start_stb), .stop_det(stop_stb), .commit_busy(busy),
        .mem_rdata(mem_rdata), .sda_oe(sda_oe), .mem_addr(mem_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .commit_req(commit_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Whenever the bench expects silence, SDA must not be driven (R2, R6, R10)
    always @(negedge clk) begin
        if (quiet) check("R2/R6/R10 silent", int'(sda_oe), 0);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic seen, input int exp_oe, input string req);
        m_sda = b;
        tick(2);
        scl = 1'b1;
        tick(2);
        seen = sda_line;
        if (exp_oe >= 0) check(req, int'(sda_oe), exp_oe);
        tick(2);
        scl = 1'b0;
        tick(2);
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        tick(2);
        scl = 1'b1;
        tick(2);
        m_sda = 1'b0;
        start_stb = 1'b1;
        tick(1);
        start_stb = 1'b0;
        tick(2);
        scl = 1'b0;
        tick(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        tick(2);
        scl = 1'b1;
        tick(2);
        m_sda = 1'b1;
        stop_stb = 1'b1;
        tick(1);
        stop_stb = 1'b0;
        tick(4);
    endtask

    task automatic send_byte(input logic [7:0] b, input int exp_ack, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s, 0, "R4 no drive while receiving");
        clk_bit(1'b1, s, -1, req);
        check(req, int'(!s), exp_ack);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit give_ack, input string req);
        logic [7:0] got;
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s, -1, req);
            got[i] = s;
        end
        check(req, int'(got), int'(exp));
        clk_bit(!give_ack, s, 0, "R6 release in ack slot");
    endtask

    task automatic read_bytes(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            recv_byte(ref_mem[ref_ptr], k != n - 1, req);
            ref_ptr = (ref_ptr + 1) % MEM_N;
        end
    endtask

    task automatic write_tx(input logic [2:0] blk, input logic [7:0] lo, input int n, input int seed);
        int c0;
        logic [7:0] d;
        c0 = commit_cnt;
        bus_start();
        send_byte({4'b1010, blk, 1'b0}, 1, "R1 write address ack");
        send_byte(lo, 1, "R3 word address ack");
        ref_ptr = int'({blk, lo});
        for (int k = 0; k < n; k++) begin
            d = 8'((seed + k * 29) & 255);
            send_byte(d, 1, "R3 data ack");
            ref_mem[ref_ptr] = d;
            ref_ptr = (ref_ptr + 1) % MEM_N;
        end
        bus_stop();
        tick(2);
        check("R12 one commit per write", commit_cnt - c0, 1);
        check("R7 pointer after write", int'(mem_addr), ref_ptr);
    endtask

    task automatic rand_read(input logic [2:0] blk, input logic [7:0] lo, input int n, input string req);
        int c0, w0;
        c0 = commit_cnt;
        w0 = wr_cnt;
        bus_start();
        send_byte({4'b1010, blk, 1'b0}, 1, "R8 dummy write address");
        send_byte(lo, 1, "R8 dummy word address");
        ref_ptr = int'({blk, lo});
        bus_start();
        send_byte({4'b1010, blk, 1'b1}, 1, "R8 read address");
        read_bytes(n, req);
        bus_stop();
        tick(2);
        check("R8 no write from dummy", wr_cnt - w0, 0);
        check("R12 no commit after dummy write", commit_cnt - c0, 0);
    endtask

    task automatic cur_read(input int n, input string req);
        bus_start();
        send_byte({4'b1010, 3'b000, 1'b1}, 1, "R1 read address ack");
        read_bytes(n, req);
        bus_stop();
        tick(2);
        check("R7 pointer after read", int'(mem_addr), ref_ptr);
    endtask

    initial begin
        logic s;
        int w0, c0;
        rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1;
        start_stb = 1'b0; stop_stb = 1'b0; busy = 1'b0; quiet = 1'b0;
        for (int i = 0; i < MEM_N; i++) begin
            mem[i]     = 8'((i * 7 + 3) & 255);
            ref_mem[i] = 8'((i * 7 + 3) & 255);
        end
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check("R13 sda_oe", int'(sda_oe), 0);
        check("R13 pointer", int'(mem_addr), 0);
        check("R13 commit_req", int'(commit_req), 0);
        check("R13 wr_en", int'(wr_en), 0);

        // R5 R6 R7: current-address sequential read from reset
        cur_read(3, "R5 read from reset pointer");

        // R1 R3 R12: byte write in block 3
        write_tx(3'd3, 8'h10, 1, 165);

        // R10: poll while busy, then after busy clears
        busy = 1'b1;
        w0 = wr_cnt;
        bus_start();
        quiet = 1'b1;
        send_byte({4'b1010, 3'd0, 1'b0}, 0, "R10 no ack while busy");
        send_byte(8'h00, 0, "R10 ignored byte");
        quiet = 1'b0;
        bus_stop();
        check("R10 no write while busy", wr_cnt - w0, 0);
        check("R10 pointer unchanged", int'(mem_addr), ref_ptr);
        busy = 1'b0;
        bus_start();
        send_byte({4'b1010, 3'd0, 1'b0}, 1, "R10 ack once idle");
        bus_stop();

        // R7: current read follows the write
        cur_read(1, "R7 current read after write");

        // R3 page of 4 bytes across a block edge, then R8 random read
        write_tx(3'd5, 8'hFE, 4, 40);
        rand_read(3'd5, 8'hFE, 4, "R8 random sequential read");

        // R9: wrap from top address
        rand_read(3'd7, 8'hFF, 3, "R9 wrap read");
        check("R9 pointer after wrap", int'(mem_addr), 2);

        // R2: foreign device code
        w0 = wr_cnt;
        c0 = commit_cnt;
        bus_start();
        quiet = 1'b1;
        send_byte(8'hB0, 0, "R2 foreign code no ack");
        send_byte(8'h44, 0, "R2 following byte ignored");
        quiet = 1'b0;
        bus_stop();
        tick(2);
        check("R2 no write", wr_cnt - w0, 0);
        check("R2 no commit", commit_cnt - c0, 0);
        check("R2 pointer unchanged", int'(mem_addr), ref_ptr);

        // R11: repeated start in mid data byte
        w0 = wr_cnt;
        c0 = commit_cnt;
        bus_start();
        send_byte({4'b1010, 3'd0, 1'b0}, 1, "R11 address");
        send_byte(8'h20, 1, "R11 word address");
        ref_ptr = 32;
        clk_bit(1'b0, s, 0, "R11 partial bit");
        clk_bit(1'b1, s, 0, "R11 partial bit");
        clk_bit(1'b0, s, 0, "R11 partial bit");
        bus_start();
        send_byte({4'b1010, 3'd0, 1'b1}, 1, "R11 address after restart");
        read_bytes(1, "R11 data untouched after abort");
        bus_stop();
        tick(2);
        check("R11 no write from partial byte", wr_cnt - w0, 0);
        check("R12 no commit without data", commit_cnt - c0, 0);

        // R6: NACK leaves the engine silent until stop
        bus_start();
        send_byte({4'b1010, 3'd0, 1'b1}, 1, "R6 read address");
        read_bytes(1, "R6 byte before nack");
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) clk_bit(1'b1, s, 0, "R6 silent after nack");
        quiet = 1'b0;
        bus_stop();
        tick(2);
        check("R6 pointer after nack", int'(mem_addr), ref_ptr);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule